// File: doc/BRIEF.md
# Modem Line Status and Loopback Unit

This unit holds the modem control byte and the modem status byte of a 16550-style serial port. It passes the four incoming handshake lines (clear-to-send, data-set-ready, carrier-detect and ring) through a synchronizer and compares each new sample with the last one it recorded. Every line that changes leaves a sticky change flag. The flags stay set until software reads the status byte, and while any flag is set a pending signal goes to the interrupt logic.

The control byte drives the request-to-send and data-terminal-ready outputs. It also holds two general-purpose output bits and a loopback bit. With loopback set, a status read no longer shows the external lines. It shows the control bits folded back onto the status positions. In this mode, control writes leave the two external handshake outputs untouched, and a status read does not clear the change flags.

Top module: `modem_line_unit`

## Requirements
- R1: While reset is low and just after it rises, the control readback is 0x08, the status readback is 0xB0, the pending output is 0, and both handshake outputs are 0.
- R2: A control write keeps only data bits 4:0: bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2 and bit 4 is LOOP. Readback bits 7:5 are always 0.
- R3: When a control write has bit 4 clear, `rts_out` takes data bit 1 and `dtr_out` takes data bit 0 on the clock edge that captures the write.
- R4: When a control write has bit 4 set, `rts_out` and `dtr_out` keep their previous values.
- R5: Status bits 7, 6, 5 and 4 follow carrier-detect, ring, data-set-ready and clear-to-send. With the default two synchronizer stages, an input change is visible on the third rising edge after it is applied.
- R6: A change on carrier-detect sets status bit 3, on data-set-ready sets bit 1, and on clear-to-send sets bit 0. These flags stay set through any number of further changes until they are cleared by a read.
- R7: Status bit 2 is set only when ring goes from 1 to 0. A 0-to-1 change of ring leaves it clear.
- R8: With loopback clear, a status read returns the current byte, and bits 3:0 are clear from the next cycle on. A change recorded on the same edge as the read is kept.
- R9: `ms_pend` is 1 exactly when at least one of the four change flags is set.
- R10: With loopback set, the status readback is {OUT2, OUT1, DTR, RTS, 4'b0000} in bits 7 to 0. A read does not clear the change flags, and the external lines are still tracked underneath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control byte readback |
| sts_rd | input | 1 | Read strobe for the status byte (clears flags) |
| sts_rdata | output | 8 | Status byte as seen by a read |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| ri_in | input | 1 | Ring line, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| ms_pend | output | 1 | Any change flag set |

## Verification
The hardest case to reach is a line change that is recorded on the same clock edge that a status read clears the flags. A flag lost at that edge would never show up in ordinary read-after-settle tests. The bench reaches this case by counting the synchronizer edges from a pin change and raising the read strobe exactly in the cycle before the third edge. A second awkward case is a change that arrives while loopback hides the lines. The bench makes a change in loopback, performs a read there, leaves loopback, and confirms that the flag survived.

// File: rtl/modem_line_pkg.sv
// Shared types for the modem line unit.
// Assumes: status upper nibble order {dcd, ri, dsr, cts} matches bits 7:4.
package modem_line_pkg;
    localparam int LINE_W = 4;
    localparam int CTL_W  = 5;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

    typedef struct packed {
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctl_t;

    localparam line_t LINE_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};
    localparam ctl_t  CTL_RST  = '{loop: 1'b0, out2: 1'b1, out1: 1'b0, rts: 1'b0, dtr: 1'b0};
endpackage

// File: rtl/mlu_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous lines.
// Assumes: STAGES >= 1; each line is synchronized on its own, so lines
// that change together may be seen one cycle apart.
module mlu_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    // Shift the sampled lines through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mlu_ctl_reg.sv
// Control byte storage and handshake output drivers.
// Assumes: wr_data carries only the five stored bits; outputs change only
// on a write whose loop bit is clear.
module mlu_ctl_reg
    import modem_line_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl,
    output logic             rts_pin,
    output logic             dtr_pin
);
    ctl_t wr_val;
    assign wr_val = ctl_t'(wr_data);

    // Capture the control byte on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl <= CTL_RST;
        else if (wr_en) ctl <= wr_val;
    end

    // Drive handshake outputs unless the written value selects loopback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_pin <= 1'b0;
            dtr_pin <= 1'b0;
        end else if (wr_en && !wr_val.loop) begin
            rts_pin <= wr_val.rts;
            dtr_pin <= wr_val.dtr;
        end
    end
endmodule

// File: rtl/mlu_status.sv
// Status byte: line state, sticky change flags and loopback view.
// Assumes: lines arrive already synchronized; a read in loopback leaves
// the flags alone.
module mlu_status
    import modem_line_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  line_t             lines,
    input  logic              rd_en,
    input  ctl_t              ctl,
    output logic [BYTE_W-1:0] rdata,
    output logic              pend
);
    line_t             cur;
    logic [LINE_W-1:0] delta;
    line_t             chg;
    logic [LINE_W-1:0] new_delta;
    logic              rd_clear;

    assign chg       = cur ^ lines;
    // Ring flag only on a fall: changed and previously high.
    assign new_delta = {chg.dcd, chg.ri & cur.ri, chg.dsr, chg.cts};
    assign rd_clear  = rd_en && !ctl.loop;

    // Record the latest line state.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= LINE_RST;
        else        cur <= lines;
    end

    // Accumulate change flags; a read clears old flags but keeps new ones.
    always_ff @(posedge clk) begin
        if (!rst_n) delta <= '0;
        else        delta <= (rd_clear ? '0 : delta) | new_delta;
    end

    // Select between line view and loopback view for reads.
    always_comb begin
        if (ctl.loop) rdata = {ctl.out2, ctl.out1, ctl.dtr, ctl.rts, 4'b0000};
        else          rdata = {cur, delta};
    end

    assign pend = |delta;
endmodule

// File: rtl/modem_line_unit.sv
// Top of the modem line unit: synchronizer, control byte, status byte.
// Assumes: strobes are single-cycle and synchronous to clk; lines are
// asynchronous and active high.
module modem_line_unit
    import modem_line_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       dcd_in,
    input  logic       ri_in,
    output logic       rts_out,
    output logic       dtr_out,
    output logic       ms_pend
);
    localparam int PAD_W = BYTE_W - CTL_W;

    line_t raw_lines;
    line_t sync_lines;
    ctl_t  ctl;
    logic  unused_wdata_hi;

    assign raw_lines       = '{dcd: dcd_in, ri: ri_in, dsr: dsr_in, cts: cts_in};
    assign unused_wdata_hi = ^ctl_wdata[BYTE_W-1:CTL_W];

    mlu_sync #(
        .W       (LINE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LINE_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    mlu_ctl_reg ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr),
        .wr_data (ctl_wdata[CTL_W-1:0]),
        .ctl     (ctl),
        .rts_pin (rts_out),
        .dtr_pin (dtr_out)
    );

    mlu_status sts_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (sync_lines),
        .rd_en (sts_rd),
        .ctl   (ctl),
        .rdata (sts_rdata),
        .pend  (ms_pend)
    );

    assign ctl_rdata = {{PAD_W{1'b0}}, ctl};
endmodule

// File: rtl/modem_line_unit_chk.sv
// Checker for the modem line unit, bound to the top module.
module modem_line_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr,
    input logic       wr_loop,
    input logic       wr_rts,
    input logic       wr_dtr,
    input logic       loop_q,
    input logic       rd,
    input logic       ri_now,
    input logic [3:0] flags,
    input logic       rts_out,
    input logic       dtr_out,
    input logic       ms_pend
);
    AST_WRITE_DRIVES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_loop) |=> (rts_out == $past(wr_rts) && dtr_out == $past(wr_dtr))); // R3

    AST_LOOP_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_loop) |=> ($stable(rts_out) && $stable(dtr_out))); // R4

    AST_RING_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_q && $past(!loop_q) && $rose(flags[2])) |-> ($past(ri_now) && !ri_now)); // R7

    AST_PEND_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_q |-> (ms_pend == (|flags))); // R9

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_pend && (!rd || loop_q)) |=> ms_pend); // R6
endmodule

bind modem_line_unit modem_line_unit_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (ctl_wr),
    .wr_loop (ctl_wdata[4]),
    .wr_rts  (ctl_wdata[1]),
    .wr_dtr  (ctl_wdata[0]),
    .loop_q  (ctl_rdata[4]),
    .rd      (sts_rd),
    .ri_now  (sts_rdata[6]),
    .flags   (sts_rdata[3:0]),
    .rts_out (rts_out),
    .dtr_out (dtr_out),
    .ms_pend (ms_pend)
);

// File: tb/modem_line_unit_tb.sv
// Directed bench: one task per scenario; inputs driven and outputs sampled at negedge.
module modem_line_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_rdata;
    logic       cts_in = 1'b1;
    logic       dsr_in = 1'b1;
    logic       dcd_in = 1'b1;
    logic       ri_in  = 1'b0;
    logic       rts_out;
    logic       dtr_out;
    logic       ms_pend;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_line_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .ri_in(ri_in),
        .rts_out(rts_out), .dtr_out(dtr_out), .ms_pend(ms_pend)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic rd_sts(output logic [7:0] v);
        v = sts_rdata; sts_rd = 1'b1;
        @(negedge clk);
        sts_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ctl during reset", ctl_rdata, 8'h08);
        rst_n = 1'b1;
        tick(1);
        chk("R1 ctl", ctl_rdata, 8'h08);
        chk("R1 status", sts_rdata, 8'hB0);
        chk("R1 pend", {7'b0, ms_pend}, 8'h00);
        chk("R1 pins", {6'b0, rts_out, dtr_out}, 8'h00);
    endtask

    task automatic t_ctl_store;
        wr_ctl(8'hE3);
        chk("R2 low five bits kept", ctl_rdata, 8'h03);
        chk("R3 pins follow write", {6'b0, rts_out, dtr_out}, 8'h03);
        wr_ctl(8'h02);
        chk("R3 rts only", {6'b0, rts_out, dtr_out}, 8'h02);
    endtask

    task automatic t_loop_pins;
        logic [7:0] v;
        wr_ctl(8'h11);
        chk("R4 loop write holds pins", {6'b0, rts_out, dtr_out}, 8'h02);
        chk("R10 loop view dtr", sts_rdata, 8'h20);
        wr_ctl(8'h1E);
        chk("R10 loop view out2 out1 rts", sts_rdata, 8'hD0);
        chk("R4 pins still held", {6'b0, rts_out, dtr_out}, 8'h02);
        cts_in = 1'b0;
        tick(3);
        chk("R10 change tracked in loop", {7'b0, ms_pend}, 8'h01);
        rd_sts(v);
        chk("R10 loop read value", v, 8'hD0);
        wr_ctl(8'h00);
        chk("R10 flag kept over loop read", sts_rdata, 8'hA1);
        chk("R3 pins after leaving loop", {6'b0, rts_out, dtr_out}, 8'h00);
        rd_sts(v);
        chk("R8 read returns current", v, 8'hA1);
        chk("R8 flags cleared", sts_rdata, 8'hA0);
        chk("R9 pend low after clear", {7'b0, ms_pend}, 8'h00);
        cts_in = 1'b1;
        tick(3);
        rd_sts(v);
        chk("R6 cts rise flag", v, 8'hB1);
    endtask

    task automatic t_sync_delay;
        logic [7:0] v;
        dsr_in = 1'b0;
        tick(1);
        chk("R5 not yet after 1 edge", sts_rdata, 8'hB0);
        tick(1);
        chk("R5 not yet after 2 edges", sts_rdata, 8'hB0);
        tick(1);
        chk("R5 visible after 3 edges", sts_rdata, 8'h92);
        chk("R9 pend set", {7'b0, ms_pend}, 8'h01);
        dsr_in = 1'b1;
        tick(3);
        chk("R6 dsr flag sticky", sts_rdata, 8'hB2);
        rd_sts(v);
        chk("R8 cleared after dsr read", sts_rdata, 8'hB0);
        dcd_in = 1'b0;
        tick(3);
        chk("R6 dcd flag", sts_rdata, 8'h38);
        rd_sts(v);
        dcd_in = 1'b1;
        tick(3);
        rd_sts(v);
        chk("R6 dcd rise flag", v, 8'hB8);
    endtask

    task automatic t_ring;
        logic [7:0] v;
        ri_in = 1'b1;
        tick(3);
        chk("R7 ring rise sets no flag", sts_rdata, 8'hF0);
        chk("R9 no pend on ring rise", {7'b0, ms_pend}, 8'h00);
        ri_in = 1'b0;
        tick(3);
        chk("R7 ring fall flag", sts_rdata, 8'hB4);
        rd_sts(v);
        chk("R8 ring flag cleared", sts_rdata, 8'hB0);
    endtask

    task automatic t_collision;
        logic [7:0] v;
        cts_in = 1'b0;
        tick(2);
        rd_sts(v);
        chk("R8 read before edge sees old", v, 8'hB0);
        chk("R8 change on read edge kept", sts_rdata, 8'hA1);
        rd_sts(v);
        cts_in = 1'b1;
        tick(3);
        rd_sts(v);
        chk("R8 final clear", sts_rdata, 8'hB0);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_ctl_store();
        t_loop_pins();
        t_sync_delay();
        t_ring();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule